// File: doc/BRIEF.md
# MII Frame Transmitter with Store-and-Forward Buffer

This block takes Ethernet frames, from the destination address through the end of the payload, as a byte stream. Each beat carries one byte plus three markers: the first byte of a frame, the last byte of a frame, and a bad-frame flag. Beats are stored in a frame FIFO. Only frames whose last byte was written without an error flag are released to the line side.

The line side sends each released frame on a 4-bit MII transmit port. It first sends the preamble and the start-of-frame delimiter. It then sends the frame bytes, followed by a CRC-32 frame check sequence that is computed one nibble per clock. The transmitter holds a minimum idle gap between frames.

Both sides run on the single MII transmit clock. The writer is throttled by a ready signal when the FIFO is full. Two threshold flags tell the writer how full the FIFO is. A frame must not be longer than the FIFO depth.

Top module: `mii_frame_tx`

## Requirements
- R1: Reset state: mii_txen is low, in_ready is high, fifo_almost_empty is high and fifo_almost_full is low.
- R2: Each frame on the wire starts with PRE_BYTES bytes of 0x55 followed by one 0xD5 byte. Each byte is sent low nibble first. mii_txen stays high without a break from the first preamble nibble to the last check-sequence nibble.
- R3: The frame bytes follow the delimiter in the order they were written, each sent low nibble first.
- R4: After the last frame byte, 4 bytes of check sequence are sent, least-significant nibble first. Their value is the bitwise inverse of a CRC-32 over the frame bytes only. The CRC uses the reflected polynomial 0xEDB88320 (normal form 0x04C11DB7) and starts from 0xFFFFFFFF.
- R5: No frame begins on the wire before its last byte has been accepted.
- R6: When a beat is accepted with in_err high, the frame containing it is never sent. Its stored bytes are released by moving the write pointer back to the frame's first entry. Later beats up to and including the frame's last beat are discarded. No stored entry that reaches the reader carries the error flag.
- R7: A beat accepted with in_first high while a frame is still open (not yet ended) discards the open frame's bytes, and a new frame starts at that beat.
- R8: A beat is accepted when in_valid and in_ready are both high at a clock edge. in_ready is low while the FIFO holds DEPTH entries. The stored count never exceeds DEPTH.
- R9: The occupancy counts written entries, including those of a frame still being written, minus entries already read. fifo_almost_full is high when occupancy >= DEPTH - AFULL_MARGIN. fifo_almost_empty is high when occupancy <= AEMPTY_LEVEL.
- R10: Between two frames, mii_txen stays low for at least IFG_CLKS clocks.
- R11: Frames are sent in the order they were completed, with no frame lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MII transmit clock, shared by both sides |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | Beat present |
| in_first | input | 1 | Beat is the first byte of a frame |
| in_last | input | 1 | Beat is the last byte of a frame |
| in_err | input | 1 | Frame is bad and must be dropped |
| in_ready | output | 1 | FIFO can take a beat |
| fifo_almost_full | output | 1 | Occupancy at or above the upper threshold |
| fifo_almost_empty | output | 1 | Occupancy at or below the lower threshold |
| mii_txen | output | 1 | MII transmit enable |
| mii_txd | output | 4 | MII transmit nibble |

## Verification
The bench builds the block with DEPTH=64, AFULL_MARGIN=8, AEMPTY_LEVEL=4, PRE_BYTES=7 and IFG_CLKS=24. With the small depth, a single open frame can fill the FIFO completely, so the full and both threshold flags can be checked at exact occupancies. Random frames of up to 48 bytes, written faster than the wire drains them, keep ready toggling during normal traffic. The preamble length and idle gap keep their normal values, so the wire format checked is the full one.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_FCS,
    ST_GAP
  } tx_state_t;

  // One FIFO word: error flag, last flag, byte
  typedef struct packed {
    logic       err;
    logic       last;
    logic [7:0] data;
  } fifo_entry_t;

  localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_REFL_POLY = 32'hEDB8_8320;
  localparam logic [3:0]  NIB_PRE       = 4'h5;
  localparam logic [3:0]  NIB_SFD_HI    = 4'hD;

  // Advance a reflected CRC-32 by four input bits, bit 0 first
  function automatic logic [31:0] crc32_nib(input logic [31:0] crc, input logic [3:0] nib);
    logic [31:0] c;
    logic        fb;
    c = crc;
    for (int i = 0; i < 4; i++) begin
      fb = c[0] ^ nib[i];
      c  = {1'b0, c[31:1]};
      if (fb) c = c ^ CRC_REFL_POLY;
    end
    return c;
  endfunction

  // Check-sequence nibble idx (0 = least significant) of the inverted CRC
  function automatic logic [3:0] fcs_nib(input logic [31:0] crc, input logic [2:0] idx);
    logic [31:0] inv;
    inv = ~crc;
    return inv[idx*4 +: 4];
  endfunction

endpackage

// File: rtl/mii_tx_fifo.sv
module mii_tx_fifo
  import mii_tx_pkg::*;
#(
  parameter int DEPTH        = 4096,
  parameter int AFULL_MARGIN = 16,
  parameter int AEMPTY_LEVEL = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic              wr_first,
  input  logic              wr_last,
  input  logic              wr_err,
  input  logic [7:0]        wr_data,
  output logic              wr_ready,
  input  logic              rd_en,
  output fifo_entry_t       rd_entry,
  output logic              rd_avail,
  output logic [PW-1:0]     used,
  output logic              almost_full,
  output logic              almost_empty,
  output logic              drop_evt
);

  fifo_entry_t mem [DEPTH];

  logic [PW-1:0] wr_ptr, frm_start, commit_ptr, rd_ptr;
  logic [PW-1:0] base_ptr, next_ptr;
  logic          dropping;
  logic          accept, skip, keep;

  assign used         = wr_ptr - rd_ptr;
  assign wr_ready     = (used != PW'(DEPTH));
  assign almost_full  = (used >= PW'(DEPTH - AFULL_MARGIN));
  assign almost_empty = (used <= PW'(AEMPTY_LEVEL));
  assign rd_avail     = (rd_ptr != commit_ptr);

  assign accept   = wr_valid && wr_ready;
  assign skip     = dropping && !wr_first;
  assign keep     = accept && !skip;
  assign base_ptr = wr_first ? frm_start : wr_ptr;
  assign next_ptr = base_ptr + PW'(1);
  assign drop_evt = keep && wr_err;

  always_ff @(posedge clk) begin
    if (keep) mem[base_ptr[AW-1:0]] <= '{err: wr_err, last: wr_last, data: wr_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      frm_start  <= '0;
      commit_ptr <= '0;
      dropping   <= 1'b0;
    end else if (keep) begin
      if (wr_err) begin
        wr_ptr   <= frm_start;
        dropping <= !wr_last;
      end else if (wr_last) begin
        wr_ptr     <= next_ptr;
        frm_start  <= next_ptr;
        commit_ptr <= next_ptr;
        dropping   <= 1'b0;
      end else begin
        wr_ptr   <= next_ptr;
        dropping <= 1'b0;
      end
    end else if (accept && wr_last) begin
      dropping <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr   <= '0;
      rd_entry <= '0;
    end else if (rd_en) begin
      rd_entry <= mem[rd_ptr[AW-1:0]];
      rd_ptr   <= rd_ptr + PW'(1);
    end
  end

endmodule

// File: rtl/mii_tx_crc.sv
module mii_tx_crc
  import mii_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        upd,
  input  logic [3:0]  nib,
  output logic [31:0] crc
);

  always_ff @(posedge clk) begin
    if (rst || init) crc <= CRC_SEED;
    else if (upd)    crc <= crc32_nib(crc, nib);
  end

endmodule

// File: rtl/mii_tx_engine.sv
module mii_tx_engine
  import mii_tx_pkg::*;
#(
  parameter int PRE_BYTES = 7,
  parameter int IFG_CLKS  = 24,
  localparam int CMAX = IFG_CLKS + PRE_BYTES + 8,
  localparam int CW   = $clog2(CMAX)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_avail,
  input  logic [7:0]  rd_data,
  input  logic        rd_last,
  output logic        rd_en,
  output logic        crc_init,
  output logic        crc_upd,
  output logic [3:0]  crc_nib,
  input  logic [31:0] crc_val,
  output logic        frame_start,
  output logic        mii_txen,
  output logic [3:0]  mii_txd
);

  tx_state_t     state;
  logic          phase;
  logic [CW-1:0] cnt;
  logic [7:0]    cur_byte;
  logic          cur_last;
  logic          en_c;
  logic [3:0]    nib_c;
  logic          at_sfd;

  assign at_sfd  = (cnt == CW'(PRE_BYTES));
  assign crc_nib = nib_c;

  always_comb begin
    en_c        = 1'b0;
    nib_c       = 4'h0;
    rd_en       = 1'b0;
    crc_init    = 1'b0;
    crc_upd     = 1'b0;
    frame_start = 1'b0;
    unique case (state)
      ST_IDLE: begin
        frame_start = rd_avail;
        crc_init    = rd_avail;
      end
      ST_PRE: begin
        en_c  = 1'b1;
        nib_c = (at_sfd && phase) ? NIB_SFD_HI : NIB_PRE;
        rd_en = at_sfd && !phase;
      end
      ST_DATA: begin
        en_c    = 1'b1;
        nib_c   = phase ? cur_byte[7:4] : cur_byte[3:0];
        crc_upd = 1'b1;
        rd_en   = !phase && !cur_last;
      end
      ST_FCS: begin
        en_c  = 1'b1;
        nib_c = fcs_nib(crc_val, cnt[2:0]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= 1'b0;
      cnt      <= '0;
      cur_byte <= '0;
      cur_last <= 1'b0;
      mii_txen <= 1'b0;
      mii_txd  <= 4'h0;
    end else begin
      mii_txen <= en_c;
      mii_txd  <= nib_c;
      unique case (state)
        ST_IDLE: begin
          if (rd_avail) begin
            state <= ST_PRE;
            cnt   <= '0;
            phase <= 1'b0;
          end
        end
        ST_PRE: begin
          phase <= !phase;
          if (phase) begin
            if (at_sfd) begin
              state    <= ST_DATA;
              cur_byte <= rd_data;
              cur_last <= rd_last;
              cnt      <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        ST_DATA: begin
          phase <= !phase;
          if (phase) begin
            if (cur_last) begin
              state <= ST_FCS;
              cnt   <= '0;
            end else begin
              cur_byte <= rd_data;
              cur_last <= rd_last;
            end
          end
        end
        ST_FCS: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(7)) begin
            state <= ST_GAP;
            cnt   <= '0;
          end
        end
        ST_GAP: begin
          cnt <= cnt + CW'(1);
          if (cnt == CW'(IFG_CLKS - 1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mii_frame_tx.sv
module mii_frame_tx
  import mii_tx_pkg::*;
#(
  parameter int DEPTH        = 4096,
  parameter int AFULL_MARGIN = 16,
  parameter int AEMPTY_LEVEL = 16,
  parameter int PRE_BYTES    = 7,
  parameter int IFG_CLKS     = 24
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_first,
  input  logic       in_last,
  input  logic       in_err,
  output logic       in_ready,
  output logic       fifo_almost_full,
  output logic       fifo_almost_empty,
  output logic       mii_txen,
  output logic [3:0] mii_txd
);

  localparam int PW = $clog2(DEPTH) + 1;

  // Internal events, named for the checker
  logic          rd_en;
  fifo_entry_t   rd_entry;
  logic          rd_avail;
  logic [PW-1:0] fifo_used;
  logic          drop_evt;
  logic          frame_start;
  logic          crc_init, crc_upd;
  logic [3:0]    crc_nib;
  logic [31:0]   crc_val;

  mii_tx_fifo #(
    .DEPTH(DEPTH), .AFULL_MARGIN(AFULL_MARGIN), .AEMPTY_LEVEL(AEMPTY_LEVEL)
  ) u_fifo (
    .clk(clk), .rst(rst),
    .wr_valid(in_valid), .wr_first(in_first), .wr_last(in_last),
    .wr_err(in_err), .wr_data(in_data), .wr_ready(in_ready),
    .rd_en(rd_en), .rd_entry(rd_entry), .rd_avail(rd_avail),
    .used(fifo_used), .almost_full(fifo_almost_full),
    .almost_empty(fifo_almost_empty), .drop_evt(drop_evt)
  );

  mii_tx_crc u_crc (
    .clk(clk), .rst(rst), .init(crc_init), .upd(crc_upd),
    .nib(crc_nib), .crc(crc_val)
  );

  mii_tx_engine #(
    .PRE_BYTES(PRE_BYTES), .IFG_CLKS(IFG_CLKS)
  ) u_engine (
    .clk(clk), .rst(rst),
    .rd_avail(rd_avail), .rd_data(rd_entry.data), .rd_last(rd_entry.last),
    .rd_en(rd_en), .crc_init(crc_init), .crc_upd(crc_upd),
    .crc_nib(crc_nib), .crc_val(crc_val), .frame_start(frame_start),
    .mii_txen(mii_txen), .mii_txd(mii_txd)
  );

endmodule

// File: rtl/mii_frame_tx_checker.sv
module mii_frame_tx_checker
  import mii_tx_pkg::*;
#(
  parameter int DEPTH    = 4096,
  parameter int IFG_CLKS = 24
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     mii_txen,
  input logic [3:0]               mii_txd,
  input logic                     in_ready,
  input logic [$clog2(DEPTH):0]   fifo_used,
  input logic                     rd_avail,
  input logic                     rd_en,
  input fifo_entry_t              rd_entry,
  input logic                     frame_start,
  input logic                     drop_evt
);

  // Idle clocks seen since the wire last carried data, saturating
  logic [15:0] low_cnt;
  always_ff @(posedge clk) begin
    if (rst)                     low_cnt <= 16'hFFFF;
    else if (mii_txen)           low_cnt <= '0;
    else if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 16'd1;
  end

  assert_preamble_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(mii_txen) |-> mii_txd == NIB_PRE);

  assert_whole_frame_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(mii_txen) |-> $past(rd_avail, 2));

  assert_start_needs_frame_R5: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !mii_txen);

  assert_rewind_shrinks_R6: assert property (@(posedge clk) disable iff (rst)
    drop_evt |=> fifo_used <= $past(fifo_used));

  assert_no_bad_entry_out_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_entry.err);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    fifo_used <= ($clog2(DEPTH) + 1)'(DEPTH));

  assert_hold_when_blocked_R8: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> fifo_used <= $past(fifo_used));

  assert_min_gap_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(mii_txen) |-> low_cnt >= 16'(IFG_CLKS));

endmodule

bind mii_frame_tx mii_frame_tx_checker #(.DEPTH(DEPTH), .IFG_CLKS(IFG_CLKS)) u_checker (
  .clk(clk), .rst(rst), .mii_txen(mii_txen), .mii_txd(mii_txd),
  .in_ready(in_ready), .fifo_used(fifo_used), .rd_avail(rd_avail),
  .rd_en(rd_en), .rd_entry(rd_entry), .frame_start(frame_start),
  .drop_evt(drop_evt)
);

// File: tb/mii_frame_tx_test.sv
`timescale 1ns/1ps
module mii_frame_tx_test;

  localparam int DEPTH  = 64;
  localparam int AFM    = 8;
  localparam int AEL    = 4;
  localparam int PREB   = 7;
  localparam int IFG    = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_err = 1'b0;
  logic       in_ready, fifo_almost_full, fifo_almost_empty, mii_txen;
  logic [3:0] mii_txd;

  always #2 clk = ~clk;

  mii_frame_tx #(
    .DEPTH(DEPTH), .AFULL_MARGIN(AFM), .AEMPTY_LEVEL(AEL),
    .PRE_BYTES(PREB), .IFG_CLKS(IFG)
  ) uut (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_first(in_first), .in_last(in_last), .in_err(in_err),
    .in_ready(in_ready), .fifo_almost_full(fifo_almost_full),
    .fifo_almost_empty(fifo_almost_empty), .mii_txen(mii_txen), .mii_txd(mii_txd)
  );

  int n_checks = 0, n_fail = 0;
  int frames_seen = 0, frames_pushed = 0, txen_cycles = 0;
  byte unsigned exp_q[$];
  int exp_len[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Byte-at-a-time reflected CRC-32
  function automatic logic [31:0] crc_byte(input logic [31:0] c, input byte unsigned b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  // ---------------- wire monitor ----------------
  logic [3:0] nibs [0:1023];
  int nn = 0, low = 0;
  bit have_prev = 0;

  function automatic byte unsigned wbyte(input int i);
    return {nibs[2*i+1], nibs[2*i]};
  endfunction

  task automatic process_frame();
    int nb, len;
    bit ok;
    logic [31:0] crc, got;
    nb = nn / 2;
    check(nn % 2 == 0, "R2 nibble count even", nn, nn + 1);
    ok = 1;
    for (int i = 0; i < PREB; i++) if (wbyte(i) != 8'h55) ok = 0;
    check(ok && wbyte(PREB) == 8'hD5, "R2 preamble/delimiter", wbyte(PREB), 8'hD5);
    if (exp_len.size() == 0) begin
      check(0, "R11 unexpected frame", nb, 0);
      return;
    end
    len = exp_len.pop_front();
    check(nb == len + PREB + 5, "R11 frame length", nb, len + PREB + 5);
    crc = 32'hFFFFFFFF;
    ok = 1;
    for (int i = 0; i < len; i++) begin
      byte unsigned e;
      e = exp_q.pop_front();
      crc = crc_byte(crc, e);
      if (wbyte(PREB + 1 + i) != e) ok = 0;
    end
    check(ok, "R3 frame bytes", ok, 1);
    got = {wbyte(PREB+len+4), wbyte(PREB+len+3), wbyte(PREB+len+2), wbyte(PREB+len+1)};
    check(got == ~crc, "R4 check sequence", got, ~crc);
    frames_seen++;
  endtask

  always @(negedge clk) begin
    if (rst) begin
      nn = 0; low = 0; have_prev = 0;
    end else if (mii_txen) begin
      txen_cycles++;
      if (nn == 0 && have_prev) check(low >= IFG, "R10 idle gap", low, IFG);
      if (nn < 1024) nibs[nn] = mii_txd;
      nn++;
      low = 0;
    end else begin
      if (nn > 0) begin
        process_frame();
        nn = 0;
        have_prev = 1;
      end
      low++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic put(input byte unsigned d, input bit f, input bit l, input bit e);
    in_valid = 1; in_data = d; in_first = f; in_last = l; in_err = e;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0; in_first = 0; in_last = 0; in_err = 0;
  endtask

  // err_pos < 0: good frame, queued as expected
  task automatic send_frame(input int len, input int err_pos, input bit gaps);
    byte unsigned b [];
    b = new[len];
    foreach (b[i]) b[i] = byte'($urandom);
    if (err_pos < 0) begin
      foreach (b[i]) exp_q.push_back(b[i]);
      exp_len.push_back(len);
      frames_pushed++;
    end
    for (int i = 0; i < len; i++) begin
      put(b[i], i == 0, i == len - 1, i == err_pos);
      if (gaps && ($urandom % 4 == 0)) repeat ($urandom % 3) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    exp_q.delete(); exp_len.delete();
    frames_seen = 0; frames_pushed = 0;
  endtask

  task automatic wait_drain();
    for (int t = 0; t < 20000; t++) begin
      if (exp_len.size() == 0 && !mii_txen && nn == 0) break;
      @(negedge clk);
    end
    repeat (IFG + 4) @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    check(!mii_txen, {tag, " R1 txen low"}, mii_txen, 0);
    check(in_ready, {tag, " R1 ready high"}, in_ready, 1);
    check(fifo_almost_empty, {tag, " R1 almost_empty"}, fifo_almost_empty, 1);
    check(!fifo_almost_full, {tag, " R1 almost_full"}, fifo_almost_full, 0);
  endtask

  initial begin
    int tx0;
    void'($urandom(32'h1234_5678));
    do_reset();
    check_reset_state("first");

    // R9 / R8: one open frame filling the FIFO, nothing released
    for (int k = 1; k <= DEPTH; k++) begin
      put(byte'(k), k == 1, 0, 0);
      if (k == AEL || k == AEL + 1)
        check(fifo_almost_empty == (k <= AEL), "R9 almost_empty threshold", fifo_almost_empty, k <= AEL);
      if (k == DEPTH - AFM - 1 || k == DEPTH - AFM)
        check(fifo_almost_full == (k >= DEPTH - AFM), "R9 almost_full threshold", fifo_almost_full, k >= DEPTH - AFM);
    end
    check(!in_ready, "R8 ready low when full", in_ready, 0);
    check(txen_cycles == 0, "R5 open frame not sent", txen_cycles, 0);
    do_reset();
    check_reset_state("second");

    // R5: held-back last byte
    exp_len.push_back(10); frames_pushed++;
    for (int i = 0; i < 10; i++) exp_q.push_back(byte'(8'hA0 + i));
    for (int i = 0; i < 9; i++) put(byte'(8'hA0 + i), i == 0, 0, 0);
    tx0 = txen_cycles;
    repeat (150) @(negedge clk);
    check(txen_cycles == tx0, "R5 no start before last byte", txen_cycles, tx0);
    put(8'hA9, 0, 1, 0);
    wait_drain();
    check(frames_seen == 1, "R5 frame sent after last byte", frames_seen, 1);

    // R6: error mid-frame and on the last beat, then good frames
    send_frame(20, 7, 0);
    send_frame(12, 11, 0);
    send_frame(15, -1, 0);
    wait_drain();
    check(frames_seen == frames_pushed, "R6 bad frames dropped", frames_seen, frames_pushed);

    // R7: open frame abandoned by a new first beat
    for (int i = 0; i < 5; i++) put(8'hEE, i == 0, 0, 0);
    send_frame(9, -1, 0);
    wait_drain();
    check(frames_seen == frames_pushed, "R7 open frame discarded", frames_seen, frames_pushed);

    // Boundary: single-byte frame and an all-ones frame
    send_frame(1, -1, 0);
    exp_len.push_back(4); frames_pushed++;
    for (int i = 0; i < 4; i++) exp_q.push_back(8'hFF);
    for (int i = 0; i < 4; i++) put(8'hFF, i == 0, i == 3, 0);
    wait_drain();

    // Random traffic, back-to-back writes outrun the wire (R8, R11)
    for (int f = 0; f < 30; f++) begin
      int len;
      len = 1 + int'($urandom % 48);
      if ($urandom % 8 == 0) send_frame(len, int'($urandom % len), f[0]);
      else                   send_frame(len, -1, f[0]);
    end
    wait_drain();
    check(frames_seen == frames_pushed, "R11 all frames delivered in order", frames_seen, frames_pushed);
    check(exp_q.size() == 0, "R11 no bytes left over", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule